// File: doc/BRIEF.md
# Rotor Stall Protection Timer

This block watches one rotor position sensor level while a brushless motor is commanded to run. A locked or blocked rotor stops that level from toggling. When no transition is seen for longer than a programmed number of system clock ticks, the block latches a fault. The fault switches off the PWM-switched half of the output bridge.

The fault stays set until the run command is withdrawn or the power-on reset is applied. While the speed target is being lowered (for example, after the reference clock is slowed), the timer is held cleared and cannot trip. A start attempted with no reference clock present is caught by the same mechanism: the rotor turns briefly, the sensor stops toggling, and the drive is shut off. While the power-on reset is held, every register stays in its reset state and nothing can trip.

Top module: `stall_guard`

## Requirements
- R1: While `rst_n` is low, `drive_off` and `watch_active` are 0 regardless of the other inputs, and a reset pulse clears a latched fault.
- R2: With `hall_in` stable, `decel_active` low and `run_cmd` high, `drive_off` rises at the (L+1)-th rising clock edge at which `run_cmd` is sampled high, where L = `timeout_ticks`.
- R3: A transition of `hall_in` in either direction restarts the timeout. A level change driven before edge k is seen as an edge after two synchronizer stages and clears the count at edge k+2. If the level stays stable from then on, the trip occurs at edge k+3+L. Toggling faster than the timeout never trips.
- R4: Once `drive_off` is set, it stays set while `run_cmd` is high, whatever `hall_in` or `decel_active` do.
- R5: `drive_off` clears at the first rising edge at which `run_cmd` is sampled low. A later run command starts a fresh full timeout.
- R6: While `decel_active` is high, the count is held at zero and no fault can be set. After it falls, a full L+1 edges of stable input are needed to trip.
- R7: With `timeout_ticks` = 0, the trip occurs at the first rising edge at which `run_cmd` is sampled high.
- R8: `watch_active` is a registered flag that equals run high, deceleration low and no fault, as of the previous edge. It is never high together with `drive_off`.
- R9: A start in which the sensor toggles a few times and then stops (no speed reference present) trips L+3 edges after the edge that registers the last transition. This is edge k+3+L, counted from the first edge after that transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hall_in | input | 1 | Monitored rotor sensor level (asynchronous) |
| run_cmd | input | 1 | 1 = run commanded, 0 = stop |
| decel_active | input | 1 | 1 while the speed target is being lowered |
| timeout_ticks | input | CNT_W | Stall timeout in clock ticks |
| drive_off | output | 1 | Latched stall fault; disables the PWM drive side |
| watch_active | output | 1 | Status: stall timer armed and counting |

## Verification
On every cycle, the embedded properties check the fault latch: it holds while running, clears in stop, and never rises during deceleration. They also check that the count is cleared by sensor edges and deceleration, that it saturates once the limit is reached, and that the armed status and the fault are exclusive. The exact trip cycle can only be shown by the bench scenarios. These cover the timeout values in the vector table, the synchronizer-delayed restart after the last sensor transition, a fresh timeout after stop or deceleration, and clearing by a reset pulse.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
    localparam int DEF_CNT_W = 24;
    localparam int DEF_SYNC  = 2;

    typedef struct packed {
        logic fault;
        logic armed;
    } latch_st_t;
endpackage

// File: rtl/hall_edge_det.sv
module hall_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_i,
    output logic edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_st_t;

    det_st_t st_q, st_d;
    logic [SYNC_STAGES-1:0] sync_next;

    if (SYNC_STAGES == 1) begin : g_single
        assign sync_next = hall_i;
    end else begin : g_chain
        assign sync_next = {st_q.sync[SYNC_STAGES-2:0], hall_i};
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_next;
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[SYNC_STAGES-1] ^ st_q.prev;
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             decel_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic    at_limit;

    assign at_limit = (st_q.cnt >= limit_i);

    always_comb begin
        st_d = st_q;
        if (!run_i || decel_i || edge_i) st_d.cnt = '0;
        else if (!at_limit)              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = at_limit;

    p_edge_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (st_q.cnt == '0));
    p_decel_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        decel_i |=> (st_q.cnt == '0));
    p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !decel_i && !edge_i && at_limit) |=> $stable(st_q.cnt));
endmodule

// File: rtl/stall_fault_latch.sv
module stall_fault_latch
    import stall_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic decel_i,
    input  logic edge_i,
    input  logic expired_i,
    output logic fault_o,
    output logic armed_o
);
    latch_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run_i)        st_d.fault = 1'b0;
        else if (st_q.fault) st_d.fault = 1'b1;
        else               st_d.fault = !decel_i && !edge_i && expired_i;
        st_d.armed = run_i && !decel_i && !st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.fault;
    assign armed_o = st_q.armed;

    p_fault_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && run_i) |=> st_q.fault);
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.fault);
    p_no_trip_decel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (decel_i && !st_q.fault) |=> !st_q.fault);
    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.fault && st_q.armed));
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_guard_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hall_in,
    input  logic             run_cmd,
    input  logic             decel_active,
    input  logic [CNT_W-1:0] timeout_ticks,
    output logic             drive_off,
    output logic             watch_active
);
    logic hall_edge;
    logic expired;

    hall_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .hall_i (hall_in),
        .edge_o (hall_edge)
    );

    stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_cmd),
        .decel_i   (decel_active),
        .edge_i    (hall_edge),
        .limit_i   (timeout_ticks),
        .expired_o (expired)
    );

    stall_fault_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_cmd),
        .decel_i   (decel_active),
        .edge_i    (hall_edge),
        .expired_i (expired),
        .fault_o   (drive_off),
        .armed_o   (watch_active)
    );

    p_trip_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_off) |-> $past(run_cmd));
endmodule

// File: tb/tb_stall_guard.sv
module tb_stall_guard;
    localparam int CNT_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hall_in = 1'b0;
    logic run_cmd = 1'b0;
    logic decel_active = 1'b0;
    logic [CNT_W-1:0] timeout_ticks = '0;
    logic drive_off, watch_active;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    stall_guard #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .run_cmd(run_cmd),
        .decel_active(decel_active), .timeout_ticks(timeout_ticks),
        .drive_off(drive_off), .watch_active(watch_active)
    );

    typedef struct packed { int limit; int trip_edges; } vec_t;
    localparam vec_t VEC [5] = '{
        '{limit: 0,  trip_edges: 1},
        '{limit: 1,  trip_edges: 2},
        '{limit: 5,  trip_edges: 6},
        '{limit: 17, trip_edges: 18},
        '{limit: 40, trip_edges: 41}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts rising edges until drive_off is seen high (sampled at negedge)
    task automatic measure(input int bound, output int n);
        n = 0;
        for (int i = 0; i < bound; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (drive_off) return;
        end
        n = -1;
    endtask

    task automatic stop_run();
        run_cmd = 1'b0;
        decel_active = 1'b0;
        cycles(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset held, run high, short timeout, sensor idle
        timeout_ticks = 3;
        run_cmd = 1'b1;
        cycles(20);
        chk("R1 drive_off in reset", drive_off, 0);
        chk("R1 watch_active in reset", watch_active, 0);
        run_cmd = 1'b0;
        rst_n = 1'b1;
        cycles(3);
        chk("R1 drive_off after reset", drive_off, 0);

        // R2 / R7: vector table of timeouts
        foreach (VEC[i]) begin
            stop_run();
            timeout_ticks = CNT_W'(VEC[i].limit);
            run_cmd = 1'b1;
            measure(200, n);
            chk(VEC[i].limit == 0 ? "R7 zero timeout trip" : "R2 trip edge",
                n, VEC[i].trip_edges);
        end

        // R8: status while armed
        stop_run();
        chk("R8 watch_active in stop", watch_active, 0);
        timeout_ticks = 20;
        run_cmd = 1'b1;
        cycles(1);
        chk("R8 watch_active armed", watch_active, 1);

        // R3: toggling faster than timeout never trips
        for (int t = 0; t < 12; t++) begin
            hall_in = ~hall_in;
            cycles(10);
        end
        chk("R3 no trip while toggling", drive_off, 0);
        // R9: rotor turned briefly, then stops: trip L+4 edges after last change
        hall_in = ~hall_in;
        measure(200, n);
        chk("R9 trip after last transition", n, 24);
        chk("R8 watch_active low on fault", watch_active, 0);

        // R4: latched despite sensor edges and deceleration
        for (int t = 0; t < 6; t++) begin
            hall_in = ~hall_in;
            cycles(3);
        end
        decel_active = 1'b1;
        cycles(5);
        chk("R4 fault held", drive_off, 1);
        decel_active = 1'b0;

        // R5: stop clears at first edge, fresh timeout afterwards
        run_cmd = 1'b0;
        cycles(1);
        chk("R5 cleared by stop", drive_off, 0);
        cycles(60);
        chk("R5 no trip in stop", drive_off, 0);
        run_cmd = 1'b1;
        measure(200, n);
        chk("R5 fresh timeout", n, 21);

        // R6: deceleration suppresses detection
        stop_run();
        run_cmd = 1'b1;
        decel_active = 1'b1;
        cycles(70);
        chk("R6 no trip in decel", drive_off, 0);
        chk("R8 watch_active low in decel", watch_active, 0);
        decel_active = 1'b0;
        measure(200, n);
        chk("R6 full timeout after decel", n, 21);

        // R1: reset pulse clears a latched fault
        rst_n = 1'b0;
        cycles(2);
        chk("R1 reset clears fault", drive_off, 0);
        rst_n = 1'b1;
        stop_run();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule